// File: doc/BRIEF.md
# Serial Port Status Flags and Interrupt Slice

This block is the register-facing status slice of an asynchronous serial port. It sits between a simple word-addressed register bus and the strobes of a receiver core and a transmitter core. On the receive side it keeps the last accepted character and three error flags: overrun, framing and noise. On the transmit side it keeps a one-character holding register, a transmit-empty flag and a transmission-complete flag. The serializer, the deserializer and the baud generator are outside the block. The block does drive out the stored baud divisor for the baud generator.

Two bus reads in a set order clear the error flags. A status read arms a pending marker and takes a snapshot of the error flags. A data read that follows then clears exactly the flags in that snapshot. Any bus write between the two reads cancels the sequence. Every data read consumes the held character. A single interrupt line combines the enabled sources.

Registers, selected by address bits [3:2] with bits [1:0] zero: 0x0 status (read only), 0x4 data, 0x8 baud divisor, 0xC control. Status bits: [0] receive full, [1] framing error, [2] noise error, [3] overrun, [4] transmission complete, [5] transmit empty. Control bits: [0] receive-full enable, [1] transmit-empty enable, [2] complete enable, [3] shared error enable.

Top module: `uart_stat_ctrl`

## Requirements
- R1: After reset, status reads 0x20 (only transmit empty set), control and baud divisor read 0, and irq is low.
- R2: An rx_done strobe while the data register is empty stores rx_char, sets status bit 0, and records rx_ferr into bit 1 and rx_nerr into bit 2.
- R3: A data read (offset 0x4) returns the held character and clears status bit 0. A second data read returns the same value and leaves bit 0 clear.
- R4: An rx_done while bit 0 is set and no data read occurs in that cycle sets overrun (bit 3). The older character is kept and the new one is dropped.
- R5: Status reads alone never clear bits 1 to 3, however many are made.
- R6: A data read that follows a status read clears only the error flags that were set at the time of that status read. Errors raised after the status read stay set.
- R7: A bus write between the status read and the data read cancels the clearing, and all error flags stay set.
- R8: A data write while the holding register is empty loads bits [8:0] into it, raises tx_hold_valid, and clears bits 5 and 4. A data write while the register is full, with no tx_take, is dropped.
- R9: tx_take while the holding register is full empties it and sets transmit empty (bit 5).
- R10: tx_shift_done sets transmission complete (bit 4) only while the holding register is empty.
- R11: irq is the OR of (bit 0 AND ctrl[0]), (bit 5 AND ctrl[1]), (bit 4 AND ctrl[2]) and (any of bits 1 to 3 AND ctrl[3]).
- R12: The baud (0x8) and control (0xC) registers read back what was written, and baud_div follows the baud register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register |
| rx_done | input | 1 | Receiver finished a character |
| rx_char | input | CHAR_W | Received character |
| rx_ferr | input | 1 | Stop bit was invalid for this character |
| rx_nerr | input | 1 | Oversampled values disagreed for this character |
| tx_hold_valid | output | 1 | Holding register has a character |
| tx_hold_data | output | CHAR_W | Character in the holding register |
| tx_take | input | 1 | Shifter takes the held character |
| tx_shift_done | input | 1 | Shifter finished its last bit |
| baud_div | output | BAUD_W | Divisor for the baud generator |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong snapshot or pending marker shows up at the first status read after the data read that was meant to clear the errors. Error bits that should stay set read back as clear, or the reverse, one cycle after the clearing read. A wrong overrun decision shows up in the character that the next data read returns: it returns the newer byte where the older one is expected. Holding-register or complete-flag mistakes show up on tx_hold_valid and status bits 4 and 5 in the cycle after the strobe. A per-cycle model comparison of bus_rdata, irq and the transmit outputs catches any of these within one clock.

// File: rtl/uart_sr_pkg.sv
package uart_sr_pkg;
  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_DATA = 2'd1,
    SEL_BAUD = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  // status bit positions
  localparam int ST_RXF = 0;
  localparam int ST_FE  = 1;
  localparam int ST_NE  = 2;
  localparam int ST_OVR = 3;
  localparam int ST_TC  = 4;
  localparam int ST_TXE = 5;
  localparam int ST_W   = 6;

  // control bit positions
  localparam int CT_RXIE  = 0;
  localparam int CT_TXIE  = 1;
  localparam int CT_TCIE  = 2;
  localparam int CT_ERRIE = 3;
  localparam int CT_W     = 4;

  // error vector order inside the receive slice
  localparam int EV_FE  = 0;
  localparam int EV_NE  = 1;
  localparam int EV_OVR = 2;
  localparam int EV_W   = 3;
endpackage

// File: rtl/usr_bus_decode.sv
module usr_bus_decode
  import uart_sr_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_e          sel,
  output logic              stat_rd,
  output logic              data_rd,
  output logic              data_wr,
  output logic              baud_wr,
  output logic              ctrl_wr,
  output logic              any_wr
);
  logic upper_ok;
  logic hit;

  generate
    if (ADDR_W > 4) begin : g_upper
      assign upper_ok = (bus_addr[ADDR_W-1:4] == '0);
    end else begin : g_no_upper
      assign upper_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    sel     = reg_sel_e'(bus_addr[3:2]);
    hit     = bus_en && upper_ok && (bus_addr[1:0] == 2'b00);
    stat_rd = hit && !bus_we && (sel == SEL_STAT);
    data_rd = hit && !bus_we && (sel == SEL_DATA);
    data_wr = hit &&  bus_we && (sel == SEL_DATA);
    baud_wr = hit &&  bus_we && (sel == SEL_BAUD);
    ctrl_wr = hit &&  bus_we && (sel == SEL_CTRL);
    any_wr  = bus_en && bus_we;
  end
endmodule

// File: rtl/usr_rx_flags.sv
module usr_rx_flags
  import uart_sr_pkg::*;
#(
  parameter int CHAR_W = 9
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              rx_done,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              rx_ferr,
  input  logic              rx_nerr,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              any_wr,
  output logic              rx_full,
  output logic [CHAR_W-1:0] rx_data,
  output logic [EV_W-1:0]   err_vec
);
  logic              full_q, full_d;
  logic [CHAR_W-1:0] data_q;
  logic              data_en;
  logic [EV_W-1:0]   err_q, err_d, err_clr;
  logic              pend_q, pend_d;
  logic [EV_W-1:0]   snap_q;
  logic              snap_en;

  always_comb begin
    err_clr = (data_rd && pend_q) ? snap_q : '0;
    err_d   = err_q & ~err_clr;
    full_d  = full_q && !data_rd;
    data_en = rx_done && (!full_q || data_rd);
    if (data_en) begin
      full_d        = 1'b1;
      err_d[EV_FE]  = err_d[EV_FE] | rx_ferr;
      err_d[EV_NE]  = err_d[EV_NE] | rx_nerr;
    end else if (rx_done) begin
      err_d[EV_OVR] = 1'b1;
    end
    snap_en = stat_rd;
    if (stat_rd)                pend_d = 1'b1;
    else if (any_wr || data_rd) pend_d = 1'b0;
    else                        pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      err_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      full_q <= full_d;
      err_q  <= err_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (data_en) data_q <= rx_char;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      snap_q <= '0;
    else if (snap_en) snap_q <= err_q;
  end

  assign rx_full = full_q;
  assign rx_data = data_q;
  assign err_vec = err_q;
endmodule

// File: rtl/usr_tx_flags.sv
module usr_tx_flags #(
  parameter int CHAR_W = 9
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              data_wr,
  input  logic [CHAR_W-1:0] wchar,
  input  logic              tx_take,
  input  logic              tx_shift_done,
  output logic              hold_full,
  output logic [CHAR_W-1:0] hold_data,
  output logic              tc
);
  logic              full_q, full_d;
  logic [CHAR_W-1:0] data_q;
  logic              tc_q, tc_d;
  logic              take_ok, load_en;

  always_comb begin
    take_ok = tx_take && full_q;
    load_en = data_wr && (!full_q || take_ok);
    if (load_en)      full_d = 1'b1;
    else if (take_ok) full_d = 1'b0;
    else              full_d = full_q;
    if (load_en)                      tc_d = 1'b0;
    else if (tx_shift_done && !full_q) tc_d = 1'b1;
    else                              tc_d = tc_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      tc_q   <= 1'b0;
    end else begin
      full_q <= full_d;
      tc_q   <= tc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (load_en) data_q <= wchar;
  end

  assign hold_full = full_q;
  assign hold_data = data_q;
  assign tc        = tc_q;
endmodule

// File: rtl/uart_stat_ctrl.sv
module uart_stat_ctrl
  import uart_sr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 9,
  parameter int BAUD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_done,
  input  logic [CHAR_W-1:0] rx_char,
  input  logic              rx_ferr,
  input  logic              rx_nerr,
  output logic              tx_hold_valid,
  output logic [CHAR_W-1:0] tx_hold_data,
  input  logic              tx_take,
  input  logic              tx_shift_done,
  output logic [BAUD_W-1:0] baud_div,
  output logic              irq
);
  logic [1:0]        sync_q;
  logic              rst_sync_n;
  reg_sel_e          sel;
  logic              stat_rd, data_rd, data_wr, baud_wr, ctrl_wr, any_wr;
  logic              rx_full;
  logic [CHAR_W-1:0] rx_data;
  logic [EV_W-1:0]   err_vec;
  logic              hold_full;
  logic [CHAR_W-1:0] hold_data;
  logic              tc;
  logic [CHAR_W-1:0] wdata_char;
  logic [BAUD_W-1:0] baud_q;
  logic [CT_W-1:0]   ctrl_ie;
  logic [ST_W-1:0]   status;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  assign wdata_char = bus_wdata[CHAR_W-1:0];

  usr_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_en  (bus_en),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .sel     (sel),
    .stat_rd (stat_rd),
    .data_rd (data_rd),
    .data_wr (data_wr),
    .baud_wr (baud_wr),
    .ctrl_wr (ctrl_wr),
    .any_wr  (any_wr)
  );

  usr_rx_flags #(.CHAR_W(CHAR_W)) u_rx (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .rx_done(rx_done),
    .rx_char(rx_char),
    .rx_ferr(rx_ferr),
    .rx_nerr(rx_nerr),
    .stat_rd(stat_rd),
    .data_rd(data_rd),
    .any_wr (any_wr),
    .rx_full(rx_full),
    .rx_data(rx_data),
    .err_vec(err_vec)
  );

  usr_tx_flags #(.CHAR_W(CHAR_W)) u_tx (
    .clk          (clk),
    .rst_ni       (rst_sync_n),
    .data_wr      (data_wr),
    .wchar        (wdata_char),
    .tx_take      (tx_take),
    .tx_shift_done(tx_shift_done),
    .hold_full    (hold_full),
    .hold_data    (hold_data),
    .tc           (tc)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  baud_q <= '0;
    else if (baud_wr) baud_q <= bus_wdata[BAUD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ctrl_ie <= '0;
    else if (ctrl_wr) ctrl_ie <= bus_wdata[CT_W-1:0];
  end

  always_comb begin
    status         = '0;
    status[ST_RXF] = rx_full;
    status[ST_FE]  = err_vec[EV_FE];
    status[ST_NE]  = err_vec[EV_NE];
    status[ST_OVR] = err_vec[EV_OVR];
    status[ST_TC]  = tc;
    status[ST_TXE] = !hold_full;
  end

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_STAT: bus_rdata[ST_W-1:0]   = status;
      SEL_DATA: bus_rdata[CHAR_W-1:0] = rx_data;
      SEL_BAUD: bus_rdata[BAUD_W-1:0] = baud_q;
      SEL_CTRL: bus_rdata[CT_W-1:0]   = ctrl_ie;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = (status[ST_RXF] & ctrl_ie[CT_RXIE])
             | (status[ST_TXE] & ctrl_ie[CT_TXIE])
             | (status[ST_TC]  & ctrl_ie[CT_TCIE])
             | ((|err_vec)     & ctrl_ie[CT_ERRIE]);

  assign tx_hold_valid = hold_full;
  assign tx_hold_data  = hold_data;
  assign baud_div      = baud_q;
endmodule

// File: rtl/uart_stat_ctrl_chk.sv
module uart_stat_ctrl_chk #(
  parameter int CHAR_W = 9
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              stat_rd,
  input logic              data_rd,
  input logic              data_wr,
  input logic              rx_done,
  input logic              rx_full,
  input logic [2:0]        err_vec,
  input logic [CHAR_W-1:0] rx_data,
  input logic              hold_full,
  input logic [CHAR_W-1:0] hold_data,
  input logic [CHAR_W-1:0] wdata_char,
  input logic              tx_take,
  input logic              tc,
  input logic [3:0]        ctrl_ie,
  input logic              irq
);
  // R3
  consume_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (data_rd && !rx_done) |=> !rx_full);

  // R4
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (rx_full && rx_done && !data_rd) |=> (err_vec[2] && $stable(rx_data)));

  // R5
  stat_keep_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    stat_rd |=> ((err_vec & $past(err_vec)) == $past(err_vec)));

  // R8
  load_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (data_wr && !hold_full) |=> (hold_full && hold_data == $past(wdata_char)));

  // R9
  take_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (tx_take && hold_full && !data_wr) |=> !hold_full);

  // R10
  tc_empty_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    tc |-> !hold_full);

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_ie == 4'b0000) |-> !irq);
endmodule

bind uart_stat_ctrl uart_stat_ctrl_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_sync_n),
  .stat_rd   (stat_rd),
  .data_rd   (data_rd),
  .data_wr   (data_wr),
  .rx_done   (rx_done),
  .rx_full   (rx_full),
  .err_vec   (err_vec),
  .rx_data   (rx_data),
  .hold_full (hold_full),
  .hold_data (hold_data),
  .wdata_char(wdata_char),
  .tx_take   (tx_take),
  .tc        (tc),
  .ctrl_ie   (ctrl_ie),
  .irq       (irq)
);

// File: tb/uart_stat_ctrl_bench.sv
module uart_stat_ctrl_bench;
  logic        clk;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        rx_done, rx_ferr, rx_nerr;
  logic [8:0]  rx_char;
  logic        tx_hold_valid;
  logic [8:0]  tx_hold_data;
  logic        tx_take, tx_shift_done;
  logic [15:0] baud_div;
  logic        irq;

  int    checks = 0;
  int    errors = 0;
  bit    run = 0;
  bit    done = 0;
  string cyc_tag = "R1";

  // behavioural model state
  bit       m_rxf, m_pend, m_hold, m_tc;
  bit [2:0] m_err, m_snap;   // {ovr, ne, fe}
  int       m_data, m_hdata, m_baud, m_ctrl;
  bit       s_st, s_dr, s_dw, s_aw, s_acc, s_tk;
  bit [2:0] s_clr;

  uart_stat_ctrl u_uart_stat_ctrl (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_done(rx_done), .rx_char(rx_char), .rx_ferr(rx_ferr), .rx_nerr(rx_nerr),
    .tx_hold_valid(tx_hold_valid), .tx_hold_data(tx_hold_data),
    .tx_take(tx_take), .tx_shift_done(tx_shift_done),
    .baud_div(baud_div), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int m_status();
    return (m_rxf ? 1 : 0) | (int'(m_err) << 1) | (m_tc ? 16 : 0) | (m_hold ? 0 : 32);
  endfunction

  function automatic bit m_irq();
    return (m_rxf && m_ctrl[0]) || (!m_hold && m_ctrl[1]) ||
           (m_tc && m_ctrl[2]) || ((m_err != 0) && m_ctrl[3]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rxf = 0; m_pend = 0; m_hold = 0; m_tc = 0;
      m_err = 0; m_snap = 0; m_data = 0; m_hdata = 0; m_baud = 0; m_ctrl = 0;
    end else begin
      s_st = bus_en && !bus_we && bus_addr == 4'h0;
      s_dr = bus_en && !bus_we && bus_addr == 4'h4;
      s_dw = bus_en &&  bus_we && bus_addr == 4'h4;
      s_aw = bus_en &&  bus_we;
      s_clr = (s_dr && m_pend) ? m_snap : 3'b000;
      if (s_st) m_snap = m_err;
      m_err = m_err & ~s_clr;
      if (rx_done) begin
        if (!m_rxf || s_dr) begin
          m_data = rx_char; m_rxf = 1;
          if (rx_ferr) m_err[0] = 1;
          if (rx_nerr) m_err[1] = 1;
        end else m_err[2] = 1;
      end else if (s_dr) m_rxf = 0;
      if (s_st) m_pend = 1;
      else if (s_aw || s_dr) m_pend = 0;
      s_tk  = tx_take && m_hold;
      s_acc = s_dw && (!m_hold || s_tk);
      if (s_acc) m_tc = 0;
      else if (tx_shift_done && !m_hold) m_tc = 1;
      if (s_acc) begin m_hold = 1; m_hdata = bus_wdata[8:0]; end
      else if (s_tk) m_hold = 0;
      if (bus_en && bus_we && bus_addr == 4'h8) m_baud = bus_wdata;
      if (bus_en && bus_we && bus_addr == 4'hC) m_ctrl = bus_wdata[3:0];
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (run && !done) begin
      #5;
      case (bus_addr)
        4'h0: chk(cyc_tag, int'(bus_rdata), m_status());
        4'h4: chk(cyc_tag, int'(bus_rdata), m_data);
        4'h8: chk(cyc_tag, int'(bus_rdata), m_baud);
        default: chk(cyc_tag, int'(bus_rdata), m_ctrl);
      endcase
      chk({cyc_tag, " irq"}, int'(irq), int'(m_irq()));
      chk({cyc_tag, " hold"}, int'(tx_hold_valid), int'(m_hold));
      if (m_hold) chk({cyc_tag, " hdata"}, int'(tx_hold_data), m_hdata);
      chk({cyc_tag, " baud"}, int'(baud_div), m_baud);
    end
  end

  task automatic drive_idle();
    bus_en = 0; bus_we = 0; bus_addr = 4'h0; bus_wdata = 16'h0;
    rx_done = 0; rx_char = 9'h0; rx_ferr = 0; rx_nerr = 0;
    tx_take = 0; tx_shift_done = 0;
  endtask

  task automatic idle();
    @(negedge clk); drive_idle();
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); drive_idle();
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic bus_rd(input logic [3:0] a, input int exp, input string tag);
    @(negedge clk); drive_idle();
    bus_en = 1; bus_addr = a;
    #2 chk(tag, int'(bus_rdata), exp);
  endtask

  task automatic rx_evt(input logic [8:0] ch, input logic fe, input logic ne);
    @(negedge clk); drive_idle();
    rx_done = 1; rx_char = ch; rx_ferr = fe; rx_nerr = ne;
  endtask

  task automatic tx_evt(input logic tk, input logic sd);
    @(negedge clk); drive_idle();
    tx_take = tk; tx_shift_done = sd;
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    @(negedge clk); drive_idle();
    #2 chk(tag, int'(irq), int'(exp));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    drive_idle();
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    run = 1;

    // R1 reset state
    cyc_tag = "R1";
    bus_rd(4'h0, 'h20, "R1 status");
    bus_rd(4'h8, 0, "R1 baud");
    bus_rd(4'hC, 0, "R1 ctrl");
    irq_chk(0, "R1 irq");

    // R12 baud register
    cyc_tag = "R12";
    bus_wr(4'h8, 16'h1234);
    idle();
    chk("R12 baud_div", int'(baud_div), 'h1234);
    bus_rd(4'h8, 'h1234, "R12 baud readback");

    // R2 / R3 clean receive and consume
    cyc_tag = "R2";
    rx_evt(9'h155, 0, 0);
    bus_rd(4'h0, 'h21, "R2 status after rx");
    cyc_tag = "R3";
    bus_rd(4'h4, 'h155, "R3 first data read");
    bus_rd(4'h0, 'h20, "R3 rxf cleared");
    bus_rd(4'h4, 'h155, "R3 second data read");
    bus_rd(4'h0, 'h20, "R3 rxf stays clear");

    // R4 overrun keeps older char
    cyc_tag = "R4";
    rx_evt(9'h0A5, 1, 0);
    bus_rd(4'h0, 'h23, "R2 framing recorded");
    rx_evt(9'h03C, 0, 0);
    bus_rd(4'h0, 'h2B, "R4 overrun set");
    bus_rd(4'h4, 'h0A5, "R4 older char kept");
    bus_rd(4'h0, 'h20, "R6 errors cleared");

    // R7 write cancels, R5 status reads keep errors
    cyc_tag = "R7";
    rx_evt(9'h011, 0, 1);
    bus_rd(4'h0, 'h25, "R2 noise recorded");
    bus_wr(4'hC, 16'h0);
    bus_rd(4'h4, 'h011, "R7 data read");
    bus_rd(4'h0, 'h24, "R7 noise kept after write");
    cyc_tag = "R5";
    idle();
    bus_rd(4'h0, 'h24, "R5 noise kept after status reads");
    bus_rd(4'h4, 'h011, "R6 clearing read");
    bus_rd(4'h0, 'h20, "R6 noise cleared");

    // R6 only snapshot flags cleared
    cyc_tag = "R6";
    rx_evt(9'h1FF, 1, 0);
    bus_rd(4'h0, 'h23, "R6 framing set");
    rx_evt(9'h002, 0, 0);
    bus_rd(4'h4, 'h1FF, "R4 older char kept again");
    bus_rd(4'h0, 'h28, "R6 late overrun survives");
    bus_rd(4'h4, 'h1FF, "R6 second clearing read");
    bus_rd(4'h0, 'h20, "R6 overrun cleared");

    // R8 R9 R10 transmit side
    cyc_tag = "R8";
    bus_wr(4'h4, 16'h01A5);
    bus_rd(4'h0, 'h00, "R8 txe cleared");
    chk("R8 hold valid", int'(tx_hold_valid), 1);
    chk("R8 hold data", int'(tx_hold_data), 'h1A5);
    bus_wr(4'h4, 16'h0077);
    idle();
    chk("R8 write while full dropped", int'(tx_hold_data), 'h1A5);
    cyc_tag = "R10";
    tx_evt(0, 1);
    bus_rd(4'h0, 'h00, "R10 no tc while full");
    cyc_tag = "R9";
    tx_evt(1, 0);
    bus_rd(4'h0, 'h20, "R9 take empties");
    chk("R9 hold valid low", int'(tx_hold_valid), 0);
    cyc_tag = "R10";
    tx_evt(0, 1);
    bus_rd(4'h0, 'h30, "R10 tc set");
    cyc_tag = "R8";
    bus_wr(4'h4, 16'h00FF);
    bus_rd(4'h0, 'h00, "R8 write clears tc");
    tx_evt(1, 0);
    tx_evt(0, 1);
    bus_rd(4'h0, 'h30, "R10 tc set again");

    // R11 interrupt combining
    cyc_tag = "R11";
    bus_wr(4'hC, 16'h0);
    irq_chk(0, "R11 all disabled");
    bus_wr(4'hC, 16'h2);
    irq_chk(1, "R11 txe source");
    bus_wr(4'hC, 16'h4);
    irq_chk(1, "R11 tc source");
    bus_wr(4'hC, 16'h1);
    irq_chk(0, "R11 rxf enabled but empty");
    rx_evt(9'h044, 0, 0);
    irq_chk(1, "R11 rxf source");
    bus_wr(4'hC, 16'h8);
    irq_chk(0, "R11 err enabled no error");
    rx_evt(9'h045, 0, 0);
    irq_chk(1, "R11 overrun source");
    cyc_tag = "R12";
    bus_rd(4'hC, 'h8, "R12 ctrl readback");
    idle();
    idle();
    finish_run();
  end
endmodule